// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits in a stereo sample path and scales both channels by a stepped gain that a mute input controls. While mute is high the gain walks down one step at a time until the output is silent. When mute goes low the gain walks back up to pass-through in the same way. Steps are paced by the sample strobe rather than by the clock, so the ramp duration is a fixed number of sample periods whatever the clock-to-sample ratio is.

The gain is a 7-bit step index. Index 127 passes samples unchanged and index 0 gives exact silence. Any index in between multiplies the sample by index/128, with the result truncated toward zero. A mute change in the middle of a ramp turns the ramp around at the current step. Very short mute pulses therefore always leave a defined gain, and the gain always recovers once mute is released. Each output pair is registered and appears one clock after its input strobe.

Top module: `smute_ramp`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0 and both outputs are 0. Reset leaves the block unmuted at gain index 127 (pass-through).
- R2: With mute held high, the gain index drops by one after every 8 accepted samples until it reaches 0. Starting from rest at 127, accepted sample number 1016 (counting from 0) is the first one output at zero gain.
- R3: With mute held low, the gain index rises by one after every 8 accepted samples until it reaches 127. Starting from rest at 0, accepted sample number 1016 is the first one passed unchanged.
- R4: A sample accepted at index 127 is output unchanged. At index 0 it is output as 0. At any other index g it is output as sample*g/128, truncated toward zero.
- R5: The left and right samples accepted in the same cycle are scaled by the same gain index.
- R6: The magnitude of each output sample never exceeds the magnitude of the input sample it came from.
- R7: If mute changes during a ramp, the ramp reverses from the current index and keeps its partly counted sample count. It does not restart.
- R8: out_valid equals in_valid delayed by one clock. The data outputs change only in the cycle after an accepted sample and otherwise hold their value.
- R9: Ramp progress counts only accepted samples (in_valid high). Mute is sampled only on those cycles, and the gain index does not change without in_valid.
- R10: A mute pulse of any length, including one shorter than 8 samples, leaves a defined index. After mute is released the gain returns to 127.
- R11: While the index rests at the end of its current direction (0 when muted, 127 when unmuted), the sample count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mute_in | input | 1 | 1 ramps down toward silence, 0 ramps up toward pass-through |
| in_valid | input | 1 | Sample strobe; one stereo pair accepted per high cycle |
| in_left | input | 18 | Left sample, two's complement |
| in_right | input | 18 | Right sample, two's complement |
| out_valid | output | 1 | Output pair strobe, one clock after in_valid |
| out_left | output | 18 | Scaled left sample |
| out_right | output | 18 | Scaled right sample |

## Verification
The properties assume that in_valid, mute_in and the sample inputs are clean synchronous levels. They also assume that mute_in matters only on strobe cycles. No assumption is made about how long mute pulses last, because the block defines its behaviour for any pulse width. The stimulus changes inputs only half a clock away from the active edge. It mixes gapped and back-to-back strobes, full-scale values of both signs, full ramps, reversals part-way through a ramp, and one- and three-sample mute pulses, and it resets in the middle of a ramp.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ramp_dir_t;
  localparam int unsigned CHANNELS = 2;
endpackage

// File: rtl/smute_step_pacer.sv
module smute_step_pacer #(
  parameter int unsigned IDX_W            = 7,
  parameter int unsigned SAMPLES_PER_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             mute,
  output logic [IDX_W-1:0] gain_idx
);
  import smute_pkg::*;

  localparam int unsigned CNT_W = (SAMPLES_PER_STEP > 1) ? $clog2(SAMPLES_PER_STEP) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLES_PER_STEP - 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_MIN  = '0;

  ramp_dir_t        dir;
  logic [CNT_W-1:0] cnt_q;
  logic             at_rest;
  logic             step_now;

  assign dir      = mute ? DIR_DOWN : DIR_UP;
  assign at_rest  = (dir == DIR_DOWN) ? (gain_idx == IDX_MIN) : (gain_idx == IDX_MAX);
  assign step_now = strobe && !at_rest && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      gain_idx <= IDX_MAX;
    end else if (strobe) begin
      if (at_rest) begin
        cnt_q <= '0;
      end else if (step_now) begin
        cnt_q    <= '0;
        gain_idx <= (dir == DIR_DOWN) ? gain_idx - 1'b1 : gain_idx + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smute_gain_mul.sv
module smute_gain_mul #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned IDX_W  = 7
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [IDX_W-1:0]  gain_idx,
  output logic signed [DATA_W-1:0] scaled
);
  localparam int unsigned PROD_W = DATA_W + IDX_W + 1;
  localparam logic [IDX_W-1:0] IDX_UNITY = {IDX_W{1'b1}};
  localparam logic signed [PROD_W-1:0] BIAS = PROD_W'((1 << IDX_W) - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    prod    = PROD_W'(sample) * $signed({1'b0, gain_idx});
    // bias negative products so the arithmetic shift truncates toward zero
    biased  = prod[PROD_W-1] ? prod + BIAS : prod;
    shifted = biased >>> IDX_W;
    scaled  = (gain_idx == IDX_UNITY) ? sample : shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp #(
  parameter int unsigned DATA_W           = 18,
  parameter int unsigned IDX_W            = 7,
  parameter int unsigned SAMPLES_PER_STEP = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mute_in,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);
  import smute_pkg::*;

  logic        [IDX_W-1:0]  gain_idx;
  logic signed [DATA_W-1:0] ch_in  [CHANNELS];
  logic signed [DATA_W-1:0] ch_mul [CHANNELS];
  logic signed [DATA_W-1:0] ch_out [CHANNELS];

  assign ch_in[0]  = in_left;
  assign ch_in[1]  = in_right;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  smute_step_pacer #(
    .IDX_W            (IDX_W),
    .SAMPLES_PER_STEP (SAMPLES_PER_STEP)
  ) u_pacer (
    .clk      (clk),
    .rst      (rst),
    .strobe   (in_valid),
    .mute     (mute_in),
    .gain_idx (gain_idx)
  );

  // one shared gain index feeds every channel (R5)
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    smute_gain_mul #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) u_mul (
      .sample   (ch_in[c]),
      .gain_idx (gain_idx),
      .scaled   (ch_mul[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ch_out[c] <= '0;
      end else if (in_valid) begin
        ch_out[c] <= ch_mul[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/smute_ramp_chk.sv
module smute_ramp_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned IDX_W  = 7
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mute_in,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic        [IDX_W-1:0]  gain_idx
);
  localparam logic [IDX_W-1:0] TOP = {IDX_W{1'b1}};

  function automatic int mag(input logic signed [DATA_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  p_reset_unity_r1: assert property (@(posedge clk) rst |=> (gain_idx == TOP && !out_valid));

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_novalid_lat_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(gain_idx));

  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    (gain_idx != $past(gain_idx)) |->
      (gain_idx == IDX_W'($past(gain_idx) + 1'b1) || gain_idx == IDX_W'($past(gain_idx) - 1'b1)));

  p_down_when_muted_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mute_in) |=> gain_idx <= $past(gain_idx));
  p_up_when_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mute_in) |=> gain_idx >= $past(gain_idx));

  p_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain_idx == '0) |=> (out_left == '0 && out_right == '0));
  p_unity_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain_idx == TOP) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

  p_no_growth_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (mag(out_left) <= mag($past(in_left)) && mag(out_right) <= mag($past(in_right))));

  p_same_gain_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_left == in_right) |=> out_left == out_right);
endmodule

bind smute_ramp smute_ramp_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mute_in   (mute_in),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right),
  .gain_idx  (gain_idx)
);

// File: tb/smute_ramp_bench.sv
module smute_ramp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int STEP = 8;
  localparam int TOPIDX = 127;
  localparam int MAXV = 131071;
  localparam int MINV = -131072;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mute_in = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_left = '0;
  logic signed [DW-1:0] in_right = '0;
  logic out_valid;
  logic signed [DW-1:0] out_left;
  logic signed [DW-1:0] out_right;

  smute_ramp u_smute_ramp (
    .clk(clk), .rst(rst), .mute_in(mute_in), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_idx = TOPIDX;
  int m_cnt = 0;
  int e_valid = 0;
  int e_l = 0;
  int e_r = 0;
  int lfsr = 32'h1d2c3;

  function automatic int scale(input int x, input int g);
    if (g == TOPIDX) return x;
    return (x * g) / 128;   // integer division truncates toward zero
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int next_rand();
    lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
    return lfsr;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_idx = TOPIDX; m_cnt = 0; e_valid = 0; e_l = 0; e_r = 0;
  endtask

  // drive at negedge, model the edge, compare at next negedge
  task automatic tick(input bit v, input bit m, input int l, input int r);
    in_valid = v; mute_in = m; in_left = DW'(l); in_right = DW'(r);
    e_valid = v;
    if (v) begin
      e_l = scale(l, m_idx);
      e_r = scale(r, m_idx);
      if (m) begin
        if (m_idx == 0) m_cnt = 0;
        else if (m_cnt == STEP-1) begin m_idx--; m_cnt = 0; end
        else m_cnt++;
      end else begin
        if (m_idx == TOPIDX) m_cnt = 0;
        else if (m_cnt == STEP-1) begin m_idx++; m_cnt = 0; end
        else m_cnt++;
      end
    end
    @(negedge clk);
    checks++;
    if (out_valid !== e_valid[0] || int'(out_left) != e_l || int'(out_right) != e_r) begin
      fails++;
      $display("FAIL %s: actual v=%0d l=%0d r=%0d expected v=%0d l=%0d r=%0d at %0t",
               cur_req, out_valid, out_left, out_right, e_valid, e_l, e_r, $time);
    end
    if (v) check("R6", (iabs(int'(out_left)) <= iabs(l)) ? 1 : 0, 1);
  endtask

  task automatic rand_sample(input bit m, input int gap_mod);
    int l = (next_rand() % 262144) - 131072;
    int r = (next_rand() % 262144) - 131072;
    bit v = (gap_mod == 0) ? 1'b1 : ((next_rand() % gap_mod) != 0);
    tick(v, m, l, r);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int first_hit;
    @(negedge clk);
    rst = 1'b1; model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", out_valid, 0);
    check("R1", int'(out_left), 0);
    check("R1", int'(out_right), 0);
    rst = 1'b0;

    // R4 unity at rest, R5 shared gain, R8 latency with gaps
    cur_req = "R4";
    tick(1, 0, MAXV, MINV);
    check("R4", int'(out_left), MAXV);
    check("R4", int'(out_right), MINV);
    cur_req = "R8";
    for (int i = 0; i < 40; i++) rand_sample(0, 3);

    // R2 full mute ramp with full-scale input
    cur_req = "R2";
    first_hit = -1;
    for (int i = 0; i < 1030; i++) begin
      tick(1, 1, MAXV, MAXV);
      if (first_hit < 0 && out_left == 0) first_hit = i;
    end
    check("R2", first_hit, 1016);
    cur_req = "R11";
    for (int i = 0; i < 20; i++) rand_sample(1, 2);
    check("R4", int'(out_left), 0);

    // R9 gaps: no progress without strobe
    cur_req = "R9";
    for (int i = 0; i < 30; i++) tick(0, 0, 77, 77);
    tick(1, 0, MAXV, -MAXV);
    check("R9", int'(out_left), 0);

    // R3 full unmute ramp (one sample already accepted above)
    cur_req = "R3";
    first_hit = -1;
    for (int i = 1; i < 1030; i++) begin
      tick(1, 0, MINV, MINV);
      if (first_hit < 0 && out_left == MINV) first_hit = i;
    end
    check("R3", first_hit, 1016);

    // R7 reversal mid ramp, with the partial count kept
    cur_req = "R7";
    for (int i = 0; i < 20; i++) tick(1, 1, 1000, -1000);
    first_hit = -1;
    for (int i = 0; i < 20; i++) begin
      tick(1, 0, 64000, -64000);
      if (first_hit < 0 && out_left == 64000) first_hit = i;
    end
    check("R7", first_hit, 12);
    for (int i = 0; i < 300; i++) rand_sample((i / 37) % 2 == 0, 4);

    // R10 short mute pulses
    cur_req = "R10";
    for (int k = 0; k < 6; k++) begin
      tick(1, 1, 5, -5);
      if (k % 2 == 0) begin tick(1, 1, 9, 9); tick(1, 1, 9, 9); end
      for (int i = 0; i < 12; i++) rand_sample(0, 0);
    end
    for (int i = 0; i < 40; i++) rand_sample(0, 0);
    tick(1, 0, 12345, -777);
    check("R10", int'(out_left), 12345);

    // R4 mid-level arithmetic on negative values, R5 shared gain
    cur_req = "R4";
    for (int i = 0; i < 500; i++) tick(1, 1, -3 - i, 3 + i);
    for (int i = 0; i < 100; i++) rand_sample(1, 0);
    cur_req = "R5";
    for (int i = 0; i < 200; i++) rand_sample(0, 2);

    // R1 reset in the middle of a ramp restores unity
    cur_req = "R1";
    for (int i = 0; i < 100; i++) rand_sample(1, 0);
    rst = 1'b1; in_valid = 1'b0; model_reset();
    @(negedge clk); @(negedge clk);
    check("R1", out_valid, 0);
    check("R1", int'(out_left), 0);
    rst = 1'b0;
    tick(1, 0, -4242, 4242);
    check("R1", int'(out_left), -4242);
    for (int i = 0; i < 20; i++) rand_sample(0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule